// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a three-level descriptor tree that sits in ordinary memory. The walk starts from a root pointer input, which gives the base of the first-level table. A requester presents a virtual address, a write flag and a supervisor flag. The walker then fetches descriptors one at a time through a single 32-bit memory port. For each word it raises a request and waits for an acknowledge.

The first level uses 8-byte descriptors: an attribute word followed by a link word. The two lower levels use 4-byte descriptors. A first-level entry can be a page descriptor, and in that case the walk ends early with a 32 MB region mapping. Otherwise the walk continues through a level-B table descriptor to a level-C page descriptor, which maps an 8 KB page.

On the way, the walker rewrites the attribute word of each valid descriptor to record that it was used. On a successful write it also sets the modified flag in the final page descriptor. The walk ends with a single-cycle done pulse. The pulse carries a fault code, the physical address, a cache-inhibit flag and the combined write-protect flag.

The state machine has these states:
- `ST_IDLE`: waits for a request.
- `ST_A_ATTR`: reads the first-level attribute word.
- `ST_A_ADDR`: reads the first-level link word.
- `ST_A_UPD`: writes back the first-level attribute word.
- `ST_B_RD`: reads the level-B descriptor.
- `ST_B_UPD`: writes back the level-B descriptor.
- `ST_C_RD`: reads the level-C descriptor.
- `ST_C_UPD`: writes back the level-C descriptor.
- `ST_DONE`: the one-cycle result state.

The transitions are:
- IDLE→A_ATTR when a request is accepted.
- A_ATTR→DONE when the entry is invalid; A_ATTR→A_ADDR otherwise.
- A_ADDR→A_UPD when the flags need an update.
- A_ADDR or A_UPD→DONE on a privilege fault or an early page end.
- A_ADDR or A_UPD→B_RD when the entry points to a table.
- B_RD→DONE when the entry is invalid.
- B_RD→B_UPD when the used flag is clear; B_RD→C_RD when it is already set.
- B_UPD→C_RD.
- C_RD→DONE when the entry is invalid.
- C_RD→C_UPD when the flags need an update.
- C_RD or C_UPD→DONE.
- DONE→IDLE.

Top module: `xlat_walker`

## Requirements
- R1: Reset puts the walker in idle. After reset, `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: The virtual address splits into four fields: bits 31-25 index level A, bits 24-19 index level B, bits 18-13 index level C, and bits 12-0 are the page offset. Level-A words are fetched from the root base (bits 31-4 of `root_ptr`, with bits 3-0 taken as zero) plus index×8: the attribute word first, then the link word at +4. A level-B entry is at the link base (bits 31-4 of the link word) plus index×4. A level-C entry is at the level-B descriptor's bits 31-4 plus index×4.
- R3: Every descriptor has a 2-bit type field in bits 1-0: 00 invalid, 01 page, 10 short table, 11 long table. The walk ends with fault code 01 (invalid) in three cases: a type of 00 at any level, a type of 01 at level B, or any type other than 01 at level C.
- R4: A level-A descriptor of type 01 ends the walk. The physical address is link-word bits 31-25 followed by virtual address bits 24-0, and `ci` is bit 6 of the attribute word.
- R5: A level-C page descriptor gives a physical address made of descriptor bits 31-13 followed by virtual address bits 12-0, and `ci` is descriptor bit 6.
- R6: Each valid descriptor the walk visits whose used bit (bit 3) is clear gets that bit set. The walker does this with one write of the attribute word only (at level A, the first word). When the used bit is already set and nothing else changes, no write is made.
- R7: A write that completes without a fault sets the modified bit (bit 4) in the final page descriptor, at level A or level C. This happens in the same write that sets the used bit.
- R8: The write-protect bits (bit 2) of all levels visited are ORed together. A write that meets any set write-protect bit ends with fault code 10 and leaves the modified bit unchanged. A read still succeeds, with `wp` set to 1.
- R9: When level-A attribute bit 8 (supervisor-only) is set and the request is not supervisor, the walk ends at level A with fault code 11. The used bit at level A is still set. No lower level is read.
- R10: `done` is a one-cycle pulse that carries the fault code (00 meaning no fault). On any fault, `pa`, `ci` and `wp` read as 0.
- R11: `req_ready` is 1 only in idle. A `req_valid` that arrives during a walk is ignored and does not change the result.
- R12: A memory request keeps its address, write enable and write data stable until `mem_ack`. `mem_we` is only asserted together with `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 32 | Level-A table base; bits 3-0 ignored |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| req_super | input | 1 | Request is made in supervisor mode |
| done | output | 1 | One-cycle result pulse |
| fault | output | 2 | 00 none, 01 invalid, 10 write-protect, 11 privilege |
| pa | output | 32 | Translated physical address |
| ci | output | 1 | Cache inhibit from the final page descriptor |
| wp | output | 1 | OR of write-protect bits along the walk |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access completes this cycle |

## Verification
The walk is tried with descriptor trees in several states:
- With every used flag clear and again with all set. This tells apart a walker that always rewrites from one that rewrites only when a flag changes.
- With write-protect placed at one level at a time. This shows whether the protection is ORed across levels and not taken from the last level only.
- With an invalid entry at each level, and with a supervisor-only entry.
- With a first-level page entry. This separates the early-exit address format from the level-C format.
- With all-ones indices, slow memory, and a second request pushed in during a walk. These expose wrong index scaling, broken handshake holding, and a walker that accepts a request while busy.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int DW = 32;

    // descriptor type field, bits 1:0
    localparam logic [1:0] DT_INV   = 2'b00;
    localparam logic [1:0] DT_PAGE  = 2'b01;
    localparam logic [1:0] DT_SHORT = 2'b10;
    localparam logic [1:0] DT_LONG  = 2'b11;

    // attribute bit positions shared by all formats
    localparam int BIT_WP    = 2;
    localparam int BIT_USED  = 3;
    localparam int BIT_MOD   = 4;
    localparam int BIT_CI    = 6;
    localparam int BIT_SUPER = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_ATTR,
        ST_A_ADDR,
        ST_A_UPD,
        ST_B_RD,
        ST_B_UPD,
        ST_C_RD,
        ST_C_UPD,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_WPROT   = 2'b10,
        FLT_PRIV    = 2'b11
    } fault_t;

    typedef enum logic [1:0] {
        LVL_A,
        LVL_B,
        LVL_C
    } level_t;

    // attribute word with used set and, optionally, modified set
    function automatic logic [DW-1:0] xw_mark(input logic [DW-1:0] w, input logic set_mod);
        logic [DW-1:0] r;
        r = w;
        r[BIT_USED] = 1'b1;
        if (set_mod) r[BIT_MOD] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/xw_fetch_addr.sv
module xw_fetch_addr
    import xw_pkg::*;
#(
    parameter int A_BITS  = 7,
    parameter int B_BITS  = 6,
    parameter int C_BITS  = 6,
    parameter int PG_BITS = 13
) (
    input  level_t          lvl,
    input  logic            second_word,
    input  logic [DW-1:0]   root,
    input  logic [DW-1:0]   base_b,
    input  logic [DW-1:0]   base_c,
    input  logic [DW-1:0]   vaddr,
    output logic [DW-1:0]   addr
);
    localparam int C_LSB = PG_BITS;
    localparam int B_LSB = PG_BITS + C_BITS;
    localparam int A_LSB = PG_BITS + C_BITS + B_BITS;
    localparam int LONG_SH  = 3;   // 8-byte entries
    localparam int SHORT_SH = 2;   // 4-byte entries

    logic [A_BITS-1:0] idx_a;
    logic [B_BITS-1:0] idx_b;
    logic [C_BITS-1:0] idx_c;

    assign idx_a = vaddr[A_LSB +: A_BITS];
    assign idx_b = vaddr[B_LSB +: B_BITS];
    assign idx_c = vaddr[C_LSB +: C_BITS];

    always_comb begin
        unique case (lvl)
            LVL_A:   addr = {root[DW-1:4], 4'h0} + (DW'(idx_a) << LONG_SH)
                            + (second_word ? DW'(4) : DW'(0));
            LVL_B:   addr = {base_b[DW-1:4], 4'h0} + (DW'(idx_b) << SHORT_SH);
            default: addr = {base_c[DW-1:4], 4'h0} + (DW'(idx_c) << SHORT_SH);
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{root[3:0], base_b[3:0], base_c[3:0], vaddr[PG_BITS-1:0]};

endmodule

// File: rtl/xw_pa_build.sv
module xw_pa_build
    import xw_pkg::*;
#(
    parameter int A_BITS  = 7,
    parameter int PG_BITS = 13
) (
    input  logic            from_c,
    input  logic [DW-1:0]   a_link,
    input  logic [DW-1:0]   c_word,
    input  logic [DW-1:0]   vaddr,
    output logic [DW-1:0]   pa
);
    localparam int REGION_BITS = DW - A_BITS;   // span of a level-A page

    always_comb begin
        if (from_c) pa = {c_word[DW-1:PG_BITS], vaddr[PG_BITS-1:0]};
        else        pa = {a_link[DW-1:REGION_BITS], vaddr[REGION_BITS-1:0]};
    end

    logic unused_bits;
    assign unused_bits = ^{a_link[REGION_BITS-1:0], c_word[PG_BITS-1:0]};

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
#(
    parameter int A_BITS  = 7,
    parameter int B_BITS  = 6,
    parameter int C_BITS  = 6,
    parameter int PG_BITS = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     root_ptr,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_vaddr,
    input  logic            req_write,
    input  logic            req_super,
    output logic            done,
    output logic [1:0]      fault,
    output logic [31:0]     pa,
    output logic            ci,
    output logic            wp,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack
);
    localparam int VA_W = A_BITS + B_BITS + C_BITS + PG_BITS;

    if (VA_W != DW) begin : g_bad_split
        $error("address field widths must add up to the data width");
    end

    walk_state_t state_q, state_d;

    logic [DW-1:0] va_q, attr_q, link_q, bdesc_q, cdesc_q;
    logic          wr_q, sup_q, wp_acc_q;
    fault_t        fault_q;
    logic [DW-1:0] pa_q;
    logic          ci_q, wpo_q;

    // level-A decode (attribute word held in attr_q)
    logic          a_page, a_priv, a_mset;
    logic [DW-1:0] a_new, a_link_w;
    assign a_page   = (attr_q[1:0] == DT_PAGE);
    assign a_priv   = attr_q[BIT_SUPER] && !sup_q;
    assign a_mset   = a_page && wr_q && !a_priv && !attr_q[BIT_WP] && !attr_q[BIT_MOD];
    assign a_new    = xw_mark(attr_q, a_mset);
    assign a_link_w = (state_q == ST_A_ADDR) ? mem_rdata : link_q;

    // level-C decode, from the bus in C_RD and from the register in C_UPD
    logic          c_wp_rd;
    logic [DW-1:0] c_new_rd, c_new_q, c_word_w;
    logic          c_wp_w;
    assign c_wp_rd  = wp_acc_q | mem_rdata[BIT_WP];
    assign c_new_rd = xw_mark(mem_rdata, wr_q && !c_wp_rd && !mem_rdata[BIT_MOD]);
    assign c_new_q  = xw_mark(cdesc_q, wr_q && !wp_acc_q && !cdesc_q[BIT_MOD]);
    assign c_word_w = (state_q == ST_C_RD) ? mem_rdata : cdesc_q;
    assign c_wp_w   = (state_q == ST_C_RD) ? c_wp_rd : wp_acc_q;

    // walk completion signals
    logic   fin_go, fin_from_c, fin_ci, fin_wp;
    fault_t fin_fault;
    logic   do_post_a, do_post_c;
    logic [DW-1:0] fin_pa;

    xw_pa_build #(.A_BITS(A_BITS), .PG_BITS(PG_BITS)) u_pa (
        .from_c (fin_from_c),
        .a_link (a_link_w),
        .c_word (c_word_w),
        .vaddr  (va_q),
        .pa     (fin_pa)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d    = state_q;
        fin_go     = 1'b0;
        fin_fault  = FLT_NONE;
        fin_from_c = 1'b0;
        fin_ci     = 1'b0;
        fin_wp     = 1'b0;
        do_post_a  = 1'b0;
        do_post_c  = 1'b0;

        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_A_ATTR;
            ST_A_ATTR: if (mem_ack) begin
                if (mem_rdata[1:0] == DT_INV) begin
                    fin_go    = 1'b1;
                    fin_fault = FLT_INVALID;
                end else begin
                    state_d = ST_A_ADDR;
                end
            end
            ST_A_ADDR: if (mem_ack) begin
                if (a_new != attr_q) state_d = ST_A_UPD;
                else                 do_post_a = 1'b1;
            end
            ST_A_UPD: if (mem_ack) do_post_a = 1'b1;
            ST_B_RD: if (mem_ack) begin
                if (!mem_rdata[1]) begin
                    fin_go    = 1'b1;
                    fin_fault = FLT_INVALID;
                end else if (!mem_rdata[BIT_USED]) begin
                    state_d = ST_B_UPD;
                end else begin
                    state_d = ST_C_RD;
                end
            end
            ST_B_UPD: if (mem_ack) state_d = ST_C_RD;
            ST_C_RD: if (mem_ack) begin
                if (mem_rdata[1:0] != DT_PAGE) begin
                    fin_go    = 1'b1;
                    fin_fault = FLT_INVALID;
                end else if (c_new_rd != mem_rdata) begin
                    state_d = ST_C_UPD;
                end else begin
                    do_post_c = 1'b1;
                end
            end
            ST_C_UPD: if (mem_ack) do_post_c = 1'b1;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase

        if (do_post_a) begin
            if (a_priv) begin
                fin_go    = 1'b1;
                fin_fault = FLT_PRIV;
            end else if (a_page) begin
                fin_go    = 1'b1;
                fin_fault = (wr_q && attr_q[BIT_WP]) ? FLT_WPROT : FLT_NONE;
                fin_ci    = attr_q[BIT_CI];
                fin_wp    = attr_q[BIT_WP];
            end else begin
                state_d = ST_B_RD;
            end
        end

        if (do_post_c) begin
            fin_go     = 1'b1;
            fin_from_c = 1'b1;
            fin_fault  = (wr_q && c_wp_w) ? FLT_WPROT : FLT_NONE;
            fin_ci     = c_word_w[BIT_CI];
            fin_wp     = c_wp_w;
        end

        if (fin_go) state_d = ST_DONE;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- walk datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            wr_q     <= 1'b0;
            sup_q    <= 1'b0;
            attr_q   <= '0;
            link_q   <= '0;
            bdesc_q  <= '0;
            cdesc_q  <= '0;
            wp_acc_q <= 1'b0;
            fault_q  <= FLT_NONE;
            pa_q     <= '0;
            ci_q     <= 1'b0;
            wpo_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q     <= req_vaddr;
                wr_q     <= req_write;
                sup_q    <= req_super;
                wp_acc_q <= 1'b0;
            end
            if (mem_ack) begin
                unique case (state_q)
                    ST_A_ATTR: attr_q <= mem_rdata;
                    ST_A_ADDR: begin
                        link_q   <= mem_rdata;
                        wp_acc_q <= attr_q[BIT_WP];
                    end
                    ST_B_RD: begin
                        bdesc_q  <= mem_rdata;
                        wp_acc_q <= wp_acc_q | mem_rdata[BIT_WP];
                    end
                    ST_C_RD: begin
                        cdesc_q  <= mem_rdata;
                        wp_acc_q <= c_wp_rd;
                    end
                    default: ;
                endcase
            end
            if (fin_go) begin
                fault_q <= fin_fault;
                if (fin_fault == FLT_NONE) begin
                    pa_q  <= fin_pa;
                    ci_q  <= fin_ci;
                    wpo_q <= fin_wp;
                end else begin
                    pa_q  <= '0;
                    ci_q  <= 1'b0;
                    wpo_q <= 1'b0;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    level_t fetch_lvl;
    logic   fetch_second;

    xw_fetch_addr #(
        .A_BITS(A_BITS), .B_BITS(B_BITS), .C_BITS(C_BITS), .PG_BITS(PG_BITS)
    ) u_addr (
        .lvl         (fetch_lvl),
        .second_word (fetch_second),
        .root        (root_ptr),
        .base_b      (link_q),
        .base_c      (bdesc_q),
        .vaddr       (va_q),
        .addr        (mem_addr)
    );

    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_wdata    = '0;
        fetch_lvl    = LVL_A;
        fetch_second = 1'b0;
        unique case (state_q)
            ST_A_ATTR: mem_req = 1'b1;
            ST_A_ADDR: begin
                mem_req      = 1'b1;
                fetch_second = 1'b1;
            end
            ST_A_UPD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = a_new;
            end
            ST_B_RD: begin
                mem_req   = 1'b1;
                fetch_lvl = LVL_B;
            end
            ST_B_UPD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                fetch_lvl = LVL_B;
                mem_wdata = xw_mark(bdesc_q, 1'b0);
            end
            ST_C_RD: begin
                mem_req   = 1'b1;
                fetch_lvl = LVL_C;
            end
            ST_C_UPD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                fetch_lvl = LVL_C;
                mem_wdata = c_new_q;
            end
            default: ;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign fault     = fault_q;
    assign pa        = pa_q;
    assign ci        = ci_q;
    assign wp        = wpo_q;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        done,
    input logic [1:0]  fault,
    input logic [31:0] pa,
    input logic        ci,
    input logic        wp,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    // R12
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R6
    wb_sets_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[3]);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'b00) |-> (pa == 32'h0 && !ci && !wp));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done));

endmodule

bind xlat_walker xlat_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .fault     (fault),
    .pa        (pa),
    .ci        (ci),
    .wp        (wp),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] root_ptr;
    logic        req_valid, req_write, req_super;
    logic [31:0] req_vaddr;
    logic        req_ready, done, ci, wp;
    logic [1:0]  fault;
    logic [31:0] pa;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    xlat_walker u_xlat_walker (
        .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_super(req_super),
        .done(done), .fault(fault), .pa(pa), .ci(ci), .wp(wp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int cnt    = 0;
    int writes_seen = 0;
    bit in_walk = 0;

    logic [31:0] mem     [logic [31:0]];
    logic [31:0] exp_mem [logic [31:0]];

    localparam logic [31:0] ROOT = 32'h0001_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: acknowledges after lat idle cycles
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    writes_seen++;
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                end
                mem_ack = 1'b1;
                cnt = 0;
            end else begin
                cnt++;
            end
        end
    end

    // per-clock comparison: nothing happens outside a walk
    always @(negedge clk) begin
        if (rst_n && !in_walk && (done || mem_req)) begin
            fails++;
            $display("FAIL R11 idle activity actual done=%b mem_req=%b expected 0 0", done, mem_req);
        end
    end

    function automatic logic [31:0] gx(input logic [31:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 32'h0;
    endfunction

    // behavioural reference walk
    function automatic void model(input logic [31:0] va, input bit wr, input bit sup,
                                  output logic [1:0] f, output logic [31:0] xpa,
                                  output bit xci, output bit xwp, output int nw);
        logic [31:0] aa, a0, a1, ba, b, ca, c, nv;
        bit wpx, pv, mset;
        f = 2'b00; xpa = 0; xci = 0; xwp = 0; nw = 0;
        aa = {ROOT[31:4], 4'h0} + {va[31:25], 3'b000};
        a0 = gx(aa);
        if (a0[1:0] == 2'b00) begin f = 2'b01; return; end
        a1 = gx(aa + 4);
        wpx = a0[2];
        pv = a0[8] && !sup;
        mset = (a0[1:0] == 2'b01) && wr && !pv && !wpx && !a0[4];
        nv = a0 | 32'h8 | (mset ? 32'h10 : 32'h0);
        if (nv != a0) begin exp_mem[aa] = nv; nw++; end
        if (pv) begin f = 2'b11; return; end
        if (a0[1:0] == 2'b01) begin
            if (wr && wpx) begin f = 2'b10; return; end
            xpa = {a1[31:25], va[24:0]}; xci = a0[6]; xwp = wpx;
            return;
        end
        ba = {a1[31:4], 4'h0} + {va[24:19], 2'b00};
        b = gx(ba);
        if (!b[1]) begin f = 2'b01; return; end
        wpx |= b[2];
        if (!b[3]) begin exp_mem[ba] = b | 32'h8; nw++; end
        ca = {b[31:4], 4'h0} + {va[18:13], 2'b00};
        c = gx(ca);
        if (c[1:0] != 2'b01) begin f = 2'b01; return; end
        wpx |= c[2];
        mset = wr && !wpx && !c[4];
        nv = c | 32'h8 | (mset ? 32'h10 : 32'h0);
        if (nv != c) begin exp_mem[ca] = nv; nw++; end
        if (wr && wpx) begin f = 2'b10; return; end
        xpa = {c[31:13], va[12:0]}; xci = c[6]; xwp = wpx;
    endfunction

    task automatic walk(input string tag, input logic [31:0] va, input bit wr,
                        input bit sup, input bit poke);
        logic [1:0] ef; logic [31:0] epa; bit eci, ewp; int enw, w0, bad;
        exp_mem = mem;
        model(va, wr, sup, ef, epa, eci, ewp, enw);
        w0 = writes_seen;
        @(negedge clk);
        in_walk = 1;
        req_vaddr = va; req_write = wr; req_super = sup; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R11 ready low while busy"}, 32'(req_ready), 32'h0);
        if (poke) begin
            req_vaddr = ~va; req_write = ~wr; req_super = ~sup; req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk({tag, " fault"}, 32'(fault), 32'(ef));
        chk({tag, " pa"},    pa, epa);
        chk({tag, " ci"},    32'(ci), 32'(eci));
        chk({tag, " wp"},    32'(wp), 32'(ewp));
        chk({tag, " writes"}, writes_seen - w0, enw);
        bad = 0;
        foreach (exp_mem[a]) if (!mem.exists(a) || mem[a] !== exp_mem[a]) bad++;
        if (mem.size() != exp_mem.size()) bad++;
        chk({tag, " memory image"}, bad, 0);
        @(negedge clk);
        in_walk = 0;
        chk({tag, " R10 done one cycle"}, 32'(done), 32'h0);
        chk({tag, " R11 ready again"}, 32'(req_ready), 32'h1);
    endtask

    task automatic put_a(input int idx, input logic [31:0] attr, input logic [31:0] link);
        mem[ROOT + idx * 8]     = attr;
        mem[ROOT + idx * 8 + 4] = link;
    endtask

    function automatic logic [31:0] mkva(input int ia, input int ib, input int ic, input int off);
        return {ia[6:0], ib[5:0], ic[5:0], off[12:0]};
    endfunction

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; root_ptr = ROOT; req_valid = 1'b0; req_write = 1'b0;
        req_super = 1'b0; req_vaddr = '0; mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'h1);
        chk("R1 done",  32'(done), 32'h0);
        chk("R1 mem_req", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // tree for A[5] -> B@0x20000[9] -> C@0x30000[17]
        put_a(5, 32'h0000_0002, 32'h0002_0000);
        mem[32'h0002_0000 + 9 * 4]  = 32'h0003_0002;
        mem[32'h0003_0000 + 17 * 4] = 32'h1234_6001;

        // R2 R5 R6: first read sets used at three levels
        walk("R2 R5 R6 full read", mkva(5, 9, 17, 13'h0abc), 0, 0, 0);
        // R6: flags already set, no write
        walk("R6 repeat read", mkva(5, 9, 17, 13'h0123), 0, 0, 0);
        // R7: write sets modified in C
        walk("R7 write marks C", mkva(5, 9, 17, 13'h1fff), 1, 0, 0);
        // R11: new request pushed in during a walk, slow memory (R12)
        lat = 2;
        walk("R11 R12 busy poke", mkva(5, 9, 17, 13'h0004), 0, 1, 1);
        lat = 0;

        // R8: write-protect at B only
        mem[32'h0002_0000 + 9 * 4] = 32'h0003_000e;
        mem[32'h0003_0000 + 17 * 4] = 32'h1234_6009;
        walk("R8 write blocked by B", mkva(5, 9, 17, 13'h0010), 1, 0, 0);
        walk("R8 read through wp", mkva(5, 9, 17, 13'h0010), 0, 0, 0);

        // R8: write-protect at A with table continuing
        put_a(11, 32'h0000_0006, 32'h0002_0000);
        mem[32'h0002_0000 + 3 * 4]  = 32'h0003_1002;
        mem[32'h0003_1000 + 2 * 4]  = 32'h5500_0041;
        walk("R8 write blocked by A", mkva(11, 3, 2, 13'h0077), 1, 0, 0);
        walk("R5 ci from C", mkva(11, 3, 2, 13'h0077), 0, 0, 0);

        // R3: invalid at each level
        walk("R3 A invalid", mkva(6, 0, 0, 0), 0, 0, 0);
        put_a(7, 32'h0000_0003, 32'h0002_1000);
        walk("R3 B invalid", mkva(7, 4, 0, 0), 0, 0, 0);
        mem[32'h0002_1000 + 5 * 4] = 32'h0003_2001;
        walk("R3 B page type invalid", mkva(7, 5, 0, 0), 0, 0, 0);
        mem[32'h0002_1000 + 6 * 4] = 32'h0003_2002;
        mem[32'h0003_2000 + 1 * 4] = 32'h7700_0002;
        walk("R3 C table type invalid", mkva(7, 6, 1, 0), 0, 0, 0);

        // R4 R7: level-A page, write sets modified in attribute word
        put_a(9, 32'h0000_0041, 32'h4600_0000);
        walk("R4 R7 A page write", {7'd9, 25'h1abcdef}, 1, 0, 0);

        // R9: supervisor-only entry
        put_a(10, 32'h0000_0102, 32'h0002_0000);
        walk("R9 user blocked", mkva(10, 9, 17, 13'h0055), 0, 0, 0);
        walk("R9 supervisor ok", mkva(10, 9, 17, 13'h0055), 0, 1, 0);

        // R2: all-ones indices
        put_a(127, 32'h0000_0002, 32'h0002_3000);
        mem[32'h0002_3000 + 63 * 4] = 32'h0003_3002;
        mem[32'h0003_3000 + 63 * 4] = 32'h0abc_d041;
        lat = 1;
        walk("R2 extreme indices", 32'hffff_ffff, 0, 0, 0);

        finish_run();
    end

endmodule